// File: doc/BRIEF.md
# Predicate Register Store Sequencer

This block carries out one store of a scalable predicate register to memory. On a start strobe it captures a 32-bit instruction word, the current vector length in 128-bit granules, a general-purpose base value, a stack-pointer value and the contents of the chosen predicate register. It then checks that the word really is a predicate store, forms the effective address and checks alignment. If all checks pass, it sends the predicate to memory one byte per valid/ready beat.

The address is the chosen base plus a signed 9-bit immediate scaled by the predicate length in bytes, with wrap modulo 2^64. The predicate length in bytes is one sixty-fourth of the vector length. Byte e carries predicate bits 8e to 8e+7 and goes to the address plus e, in rising order. Each beat also carries a flag that tells the memory side whether tag checking applies. The register-select fields come straight out of the instruction word, so a register file can supply the base and predicate values in the same cycle as the start strobe. The run ends with a one-cycle done pulse, or with a one-cycle fault pulse and a reason code. No byte is written when the run faults.

Top module: `pred_store_seq`

## Requirements
- R1: A word is accepted only when bits 31:22 are 1110010110, bits 15:13 are 000 and bit 4 is 0, and the granule count is between 1 and MAX_VL/128. Any other case gives a fault with kind 1 (illegal) and no byte write. Illegal takes priority over the alignment faults.
- R2: The immediate is {bits 21:16, bits 12:10}, read as a signed 9-bit value (-256..255). The effective address is base + imm × (byte count), with wrap modulo 2^64.
- R3: The byte count is 2 × granules. Beat e, for e = 0 to count-1 in that order, writes predicate bits [8e+7:8e] to the effective address + e (mod 2^64), with no byte swap.
- R4: Base field bits 9:5 equal to 31 take the stack-pointer value and send every beat with the tag flag at 0. Any other value takes the general-purpose value with the tag flag at 1. baseSel shows bits 9:5 and predSel shows bits 3:0 of the input word.
- R5: If alignment enforcement is on and base bit 0 is 1, the run gives a fault with kind 3 and no byte write. If enforcement is off, the store goes ahead at the odd address.
- R6: If the stack-pointer check is on, the stack pointer is selected and its bits 3:0 are not zero, the run gives a fault with kind 2 and no byte write. This takes priority over kind 3.
- R7: While wrValid is high and wrReady is low, wrAddr, wrData and wrTagChk do not change, and wrValid stays high.
- R8: After reset no request, done or fault is active. Done is high for exactly the one cycle after the last byte is accepted. Fault is high for exactly one cycle, two cycles after the start edge, and in that cycle faultKind shows the reason. Done and fault are never both high in one run.
- R9: With wrReady held high, done is seen count+2 cycles after the start edge. The cycle count never depends on the predicate data.
- R10: A start strobe while busy is high is ignored: the run in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture inputs and begin a run (when idle) |
| instr | input | 32 | Instruction word |
| granules | input | GW | Current vector length in 128-bit granules |
| gprVal | input | 64 | General-purpose register value for baseSel |
| spVal | input | 64 | Stack-pointer value |
| predVal | input | MAX_VL/8 | Predicate register contents for predSel |
| alignEnforce | input | 1 | Enable the 2-byte base alignment fault |
| spAlignCheck | input | 1 | Enable the 16-byte stack-pointer check |
| baseSel | output | 5 | Base register index taken from instr |
| predSel | output | 4 | Predicate register index taken from instr |
| busy | output | 1 | A run is in progress |
| wrValid | output | 1 | Byte write request valid |
| wrReady | input | 1 | Byte write accepted |
| wrAddr | output | 64 | Byte write address |
| wrData | output | 8 | Byte write data |
| wrTagChk | output | 1 | Tag check applies to this write |
| done | output | 1 | One-cycle pulse: store complete |
| fault | output | 1 | One-cycle pulse: store refused |
| faultKind | output | 2 | 1 illegal, 2 stack misaligned, 3 base misaligned; 0 outside fault |

## Verification
Two events can fall in the same cycle. A new start strobe can arrive while a beat is stalled or accepted. A word can also trip more than one refusal cause at once, for example an illegal pattern together with a misaligned stack pointer, or a misaligned stack pointer together with an odd base. The bench pulses start in the middle of a stalled transfer, with a different, illegal word. It judges the result by the exact beat list, a single done and the absence of a fault. It also feeds words with several causes at once and checks that only the higher-priority kind is reported, in the fixed fault cycle, with no writes.

// File: rtl/pst_pkg.sv
package pst_pkg;

  typedef enum logic [1:0] {
    FK_NONE    = 2'd0,
    FK_ILLEGAL = 2'd1,
    FK_SPALIGN = 2'd2,
    FK_ALIGN   = 2'd3
  } faultKindE;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobeS;

  // datapath -> control status
  typedef struct packed {
    logic legal;
    logic spFault;
    logic alFault;
    logic last;
  } dpStatusS;

  localparam logic [9:0] OPC_HI = 10'b1110010110;
  localparam int unsigned ADDR_W = 64;

endpackage

// File: rtl/pst_dpath.sv
module pst_dpath
  import pst_pkg::*;
#(
  parameter int unsigned MAX_VL = 2048
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeS             strobe,
  input  logic [31:0]            instr,
  input  logic [$clog2(MAX_VL/128+1)-1:0] granules,
  input  logic [ADDR_W-1:0]      gprVal,
  input  logic [ADDR_W-1:0]      spVal,
  input  logic [MAX_VL/8-1:0]    predVal,
  input  logic                   alignEnforce,
  input  logic                   spAlignCheck,
  input  logic                   wrValid,
  input  logic                   wrReady,
  output dpStatusS               status,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [7:0]             wrData,
  output logic                   wrTagChk
);

  localparam int unsigned MAX_GRAN = MAX_VL / 128;
  localparam int unsigned GW       = $clog2(MAX_GRAN + 1);
  localparam int unsigned PW       = MAX_VL / 8;
  localparam int unsigned MAXB     = MAX_VL / 64;
  localparam int unsigned IW       = (MAXB > 1) ? $clog2(MAXB) : 1;
  localparam int unsigned CW       = IW + 1;
  localparam int unsigned PRW      = 9 + CW + 1;

  // captured operands
  logic [31:4]       instrQ;
  logic [GW-1:0]     granQ;
  logic [ADDR_W-1:0] baseQ;
  logic [PW-1:0]     predQ;
  logic              alEnQ;
  logic              spChkQ;
  logic [IW-1:0]     idxQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      granQ  <= '0;
      baseQ  <= '0;
      predQ  <= '0;
      alEnQ  <= 1'b0;
      spChkQ <= 1'b0;
      idxQ   <= '0;
    end else if (strobe.load) begin
      instrQ <= instr[31:4];
      granQ  <= granules;
      baseQ  <= (instr[9:5] == 5'd31) ? spVal : gprVal;
      predQ  <= predVal;
      alEnQ  <= alignEnforce;
      spChkQ <= spAlignCheck;
      idxQ   <= '0;
    end else if (strobe.advance) begin
      idxQ <= idxQ + IW'(1);
    end
  end

  // decode
  logic          useSp;
  logic          patternOk;
  logic          granOk;
  logic [CW-1:0] byteCnt;

  assign useSp     = (instrQ[9:5] == 5'd31);
  assign patternOk = (instrQ[31:22] == OPC_HI) && (instrQ[15:13] == 3'b000)
                     && (instrQ[4] == 1'b0);
  assign granOk    = (granQ != '0) && (granQ <= GW'(MAX_GRAN));
  assign byteCnt   = CW'({granQ, 1'b0});

  // scaled offset
  logic signed [8:0]     immS;
  logic signed [PRW-1:0] prod;
  logic [ADDR_W-1:0]     offset;
  logic [ADDR_W-1:0]     effAddr;

  assign immS    = $signed({instrQ[21:16], instrQ[12:10]});
  assign prod    = $signed({{(PRW-9){immS[8]}}, immS})
                 * $signed({{(PRW-CW){1'b0}}, byteCnt});
  assign offset  = {{(ADDR_W-PRW){prod[PRW-1]}}, prod};
  assign effAddr = baseQ + offset;

  // byte lanes of the predicate
  logic [7:0] predBytes [MAXB];
  for (genvar gi = 0; gi < MAXB; gi++) begin : g_lane
    assign predBytes[gi] = predQ[gi*8 +: 8];
  end

  assign wrAddr   = effAddr + {{(ADDR_W-IW){1'b0}}, idxQ};
  assign wrData   = predBytes[idxQ];
  assign wrTagChk = !useSp;

  assign status.legal   = patternOk && granOk;
  assign status.spFault = useSp && spChkQ && (baseQ[3:0] != 4'd0);
  assign status.alFault = alEnQ && baseQ[0];
  assign status.last    = ((CW'(idxQ) + CW'(1)) == byteCnt);

  // R7: a stalled beat keeps its payload
  a_r7_hold_payload: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> ($stable(wrAddr) && $stable(wrData) && $stable(wrTagChk)));

  // R3: accepted non-final beat moves to the next byte address
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && !status.last) |=> (wrAddr == $past(wrAddr) + 64'd1));

endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wrReady,
  input  dpStatusS   status,
  output ctrlStrobeS strobe,
  output logic       busy,
  output logic       wrValid,
  output logic       done,
  output logic       fault,
  output logic [1:0] faultKind
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DECODE, ST_SEND, ST_DONE, ST_FAULT
  } stateE;

  stateE     stateQ, stateD;
  faultKindE kindQ, kindD;

  always_comb begin
    kindD = FK_NONE;
    if (!status.legal)       kindD = FK_ILLEGAL;
    else if (status.spFault) kindD = FK_SPALIGN;
    else if (status.alFault) kindD = FK_ALIGN;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:   if (start) stateD = ST_DECODE;
      ST_DECODE: stateD = (kindD == FK_NONE) ? ST_SEND : ST_FAULT;
      ST_SEND:   if (wrReady && status.last) stateD = ST_DONE;
      ST_DONE:   stateD = ST_IDLE;
      ST_FAULT:  stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      kindQ  <= FK_NONE;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_DECODE) kindQ <= kindD;
    end
  end

  assign strobe.load    = (stateQ == ST_IDLE) && start;
  assign strobe.advance = (stateQ == ST_SEND) && wrReady && !status.last;

  assign busy      = (stateQ != ST_IDLE);
  assign wrValid   = (stateQ == ST_SEND);
  assign done      = (stateQ == ST_DONE);
  assign fault     = (stateQ == ST_FAULT);
  assign faultKind = fault ? kindQ : FK_NONE;

  // R1: an illegal word is refused with the illegal code
  a_r1_illegal_refused: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_DECODE && !status.legal) |=> (fault && faultKind == FK_ILLEGAL));

  // R8: done and fault are single-cycle pulses
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rstN)
    fault |=> (!fault && !wrValid));

  // R3: acceptance of the final beat ends the run
  a_r3_last_ends: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady && status.last) |=> (done && !wrValid));

  // R10: a start strobe while busy does not begin a new run
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (stateQ != ST_DECODE));

endmodule

// File: rtl/pred_store_seq.sv
module pred_store_seq
  import pst_pkg::*;
#(
  parameter int unsigned MAX_VL = 2048
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                start,
  input  logic [31:0]                         instr,
  input  logic [$clog2(MAX_VL/128+1)-1:0]     granules,
  input  logic [63:0]                         gprVal,
  input  logic [63:0]                         spVal,
  input  logic [MAX_VL/8-1:0]                 predVal,
  input  logic                                alignEnforce,
  input  logic                                spAlignCheck,
  output logic [4:0]                          baseSel,
  output logic [3:0]                          predSel,
  output logic                                busy,
  output logic                                wrValid,
  input  logic                                wrReady,
  output logic [63:0]                         wrAddr,
  output logic [7:0]                          wrData,
  output logic                                wrTagChk,
  output logic                                done,
  output logic                                fault,
  output logic [1:0]                          faultKind
);

  ctrlStrobeS strobe;
  dpStatusS   status;

  assign baseSel = instr[9:5];
  assign predSel = instr[3:0];

  pst_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .wrReady   (wrReady),
    .status    (status),
    .strobe    (strobe),
    .busy      (busy),
    .wrValid   (wrValid),
    .done      (done),
    .fault     (fault),
    .faultKind (faultKind)
  );

  pst_dpath #(.MAX_VL(MAX_VL)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .instr        (instr),
    .granules     (granules),
    .gprVal       (gprVal),
    .spVal        (spVal),
    .predVal      (predVal),
    .alignEnforce (alignEnforce),
    .spAlignCheck (spAlignCheck),
    .wrValid      (wrValid),
    .wrReady      (wrReady),
    .status       (status),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .wrTagChk     (wrTagChk)
  );

endmodule

// File: tb/pred_store_seq_tb.sv
module pred_store_seq_tb;

  localparam int MAX_VL = 2048;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  instr = '0;
  logic [4:0]   granules = '0;
  logic [63:0]  gprVal = '0;
  logic [63:0]  spVal = '0;
  logic [255:0] predVal = '0;
  logic         alignEnforce = 1'b0;
  logic         spAlignCheck = 1'b0;
  logic         wrReady = 1'b1;
  logic [4:0]   baseSel;
  logic [3:0]   predSel;
  logic         busy, wrValid, wrTagChk, done, fault;
  logic [63:0]  wrAddr;
  logic [7:0]   wrData;
  logic [1:0]   faultKind;

  always #5 clk = ~clk;

  pred_store_seq #(.MAX_VL(MAX_VL)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .granules(granules),
    .gprVal(gprVal), .spVal(spVal), .predVal(predVal),
    .alignEnforce(alignEnforce), .spAlignCheck(spAlignCheck),
    .baseSel(baseSel), .predSel(predSel), .busy(busy), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData), .wrTagChk(wrTagChk),
    .done(done), .fault(fault), .faultKind(faultKind)
  );

  int nChecks = 0;
  int nFails  = 0;

  // capture of accepted beats
  int          capCount;
  logic [63:0] capAddr [64];
  logic [7:0]  capData [64];
  logic        capTag  [64];
  int          doneCnt, faultCnt;
  logic [15:0] lfsr = 16'hACE1;
  bit          stallOn = 1'b0;
  bit          prevStall = 1'b0;
  logic [63:0] prevAddr;
  logic [7:0]  prevData;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ready drive and monitor at the falling edge
  always @(negedge clk) begin
    if (stallOn) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wrReady = lfsr[0] | lfsr[3];
    end else begin
      wrReady = 1'b1;
    end
    if (prevStall) begin
      chk(wrValid && wrAddr == prevAddr && wrData == prevData, "R7",
          "stalled beat changed", wrAddr, prevAddr);
    end
    prevStall = wrValid && !wrReady;
    prevAddr  = wrAddr;
    prevData  = wrData;
    if (wrValid && wrReady && capCount < 64) begin
      capAddr[capCount] = wrAddr;
      capData[capCount] = wrData;
      capTag[capCount]  = wrTagChk;
      capCount++;
    end
    if (done)  doneCnt++;
    if (fault) faultCnt++;
  end

  function automatic logic [31:0] mkInstr(input logic [8:0] imm, input logic [4:0] rn,
                                          input logic [3:0] pt);
    return {10'b1110010110, imm[8:3], 3'b000, imm[2:0], rn, 1'b0, pt};
  endfunction

  function automatic longint immOf(input logic [31:0] w);
    logic [8:0] i9;
    i9 = {w[21:16], w[12:10]};
    return i9[8] ? longint'(i9) - 512 : longint'(i9);
  endfunction

  int          lastCycles;
  int          lastKind;
  bit          lastDone;

  task automatic runOp(input logic [31:0] w, input logic [4:0] gr,
                       input logic [63:0] gpr, input logic [63:0] sp,
                       input logic [255:0] pd, input bit alE, input bit spC,
                       input int restartAt);
    @(negedge clk);
    #1 lfsr = 16'hBEEF;
    @(negedge clk);
    instr = w; granules = gr; gprVal = gpr; spVal = sp; predVal = pd;
    alignEnforce = alE; spAlignCheck = spC;
    capCount = 0; doneCnt = 0; faultCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lastCycles = 1;
    while (!done && !fault && lastCycles < 3000) begin
      if (restartAt != 0 && lastCycles == restartAt) begin
        start = 1'b1;
        instr = 32'hFFFF_FFFF;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lastCycles++;
    end
    start = 1'b0;
    chk(lastCycles < 3000, "R8", "run did not end", 64'(lastCycles), 64'd0);
    lastKind = int'(faultKind);
    lastDone = done;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkStore(input string req, input logic [31:0] w, input logic [4:0] gr,
                            input logic [63:0] base, input logic [255:0] pd,
                            input bit expTag);
    int n;
    logic [63:0] ea;
    n  = 2 * int'(gr);
    ea = base + 64'(immOf(w) * longint'(n));
    chk(lastDone && faultCnt == 0 && doneCnt == 1, req, "done/fault",
        {lastDone, 31'(faultCnt), 32'(doneCnt)}, {1'b1, 31'd0, 32'd1});
    chk(capCount == n, req, "beat count", 64'(capCount), 64'(n));
    for (int e = 0; e < n && e < capCount; e++) begin
      chk(capAddr[e] == ea + 64'(e), req, $sformatf("addr beat %0d", e),
          capAddr[e], ea + 64'(e));
      chk(capData[e] == pd[8*e +: 8], req, $sformatf("data beat %0d", e),
          64'(capData[e]), 64'(pd[8*e +: 8]));
      chk(capTag[e] == expTag, "R4", $sformatf("tag beat %0d", e),
          64'(capTag[e]), 64'(expTag));
    end
  endtask

  task automatic checkFault(input string req, input int expKind);
    chk(!lastDone && lastKind == expKind && faultCnt == 1 && doneCnt == 0, req,
        "fault kind", 64'(lastKind), 64'(expKind));
    chk(capCount == 0, req, "bytes written on fault", 64'(capCount), 64'd0);
    chk(lastCycles == 2, "R8", "fault timing", 64'(lastCycles), 64'd2);
  endtask

  localparam logic [255:0] PAT_A = {8{32'h8421_F00D}} ^ {32{8'h5A}};
  localparam logic [255:0] PAT_B = ~PAT_A;

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !wrValid && !done && !fault, "R8", "reset outputs",
        {busy, wrValid, done, fault}, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !wrValid && !done && !fault, "R8", "idle after reset",
        {busy, wrValid, done, fault}, 4'b0);
  endtask

  task automatic t_basic();
    logic [31:0] w;
    w = mkInstr(9'd0, 5'd3, 4'd7);
    instr = w;
    #1;
    chk(baseSel == 5'd3 && predSel == 4'd7, "R4", "select outputs",
        {baseSel, predSel}, {5'd3, 4'd7});
    runOp(w, 5'd1, 64'h1000, 64'h0, PAT_A, 1'b1, 1'b1, 0);
    checkStore("R3", w, 5'd1, 64'h1000, PAT_A, 1'b1);
    chk(lastCycles == 4, "R9", "done timing n=2", 64'(lastCycles), 64'd4);
  endtask

  task automatic t_offsets();
    logic [31:0] w;
    w = mkInstr(9'd5, 5'd0, 4'd1);
    runOp(w, 5'd16, 64'h2000_0000, 64'h0, PAT_A, 1'b1, 1'b0, 0);
    checkStore("R2", w, 5'd16, 64'h2000_0000, PAT_A, 1'b1);
    chk(lastCycles == 34, "R9", "done timing n=32", 64'(lastCycles), 64'd34);
    w = mkInstr(9'h100, 5'd4, 4'd2);   // -256
    runOp(w, 5'd2, 64'h40, 64'h0, PAT_B, 1'b1, 1'b0, 0);
    checkStore("R2", w, 5'd2, 64'h40, PAT_B, 1'b1);
    w = mkInstr(9'd255, 5'd9, 4'd3);   // wraps past the top
    runOp(w, 5'd16, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkStore("R2", w, 5'd16, 64'hFFFF_FFFF_FFFF_FF00, PAT_A, 1'b1);
    w = mkInstr(9'h1FF, 5'd1, 4'd0);   // -1, beats cross zero
    runOp(w, 5'd8, 64'h4, 64'h0, PAT_B, 1'b1, 1'b0, 0);
    checkStore("R3", w, 5'd8, 64'h4, PAT_B, 1'b1);
  endtask

  task automatic t_stack();
    logic [31:0] w;
    w = mkInstr(9'd3, 5'd31, 4'd15);
    runOp(w, 5'd4, 64'h1111, 64'h7FF0, PAT_A, 1'b1, 1'b1, 0);
    checkStore("R4", w, 5'd4, 64'h7FF0, PAT_A, 1'b0);
    runOp(w, 5'd4, 64'h1111, 64'h7FF8, PAT_A, 1'b1, 1'b1, 0);
    checkFault("R6", 2);
    runOp(w, 5'd4, 64'h1111, 64'h7FF8, PAT_A, 1'b1, 1'b0, 0);
    checkStore("R6", w, 5'd4, 64'h7FF8, PAT_A, 1'b0);
    runOp(w, 5'd4, 64'h0, 64'h7FF3, PAT_A, 1'b1, 1'b1, 0);   // both causes
    checkFault("R6", 2);
  endtask

  task automatic t_align();
    logic [31:0] w;
    w = mkInstr(9'd1, 5'd7, 4'd4);
    runOp(w, 5'd2, 64'h3001, 64'h0, PAT_B, 1'b1, 1'b1, 0);
    checkFault("R5", 3);
    runOp(w, 5'd2, 64'h3001, 64'h0, PAT_B, 1'b0, 1'b1, 0);
    checkStore("R5", w, 5'd2, 64'h3001, PAT_B, 1'b1);
  endtask

  task automatic t_illegal();
    logic [31:0] w;
    w = mkInstr(9'd0, 5'd2, 4'd1);
    runOp(w ^ 32'h8000_0000, 5'd2, 64'h100, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkFault("R1", 1);
    runOp(w | 32'h0000_2000, 5'd2, 64'h100, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkFault("R1", 1);
    runOp(w | 32'h0000_0010, 5'd2, 64'h100, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkFault("R1", 1);
    runOp(w, 5'd0, 64'h100, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkFault("R1", 1);
    runOp(w, 5'd17, 64'h100, 64'h0, PAT_A, 1'b0, 1'b0, 0);
    checkFault("R1", 1);
    w = mkInstr(9'd0, 5'd31, 4'd1) ^ 32'h0040_0000;           // illegal and SP odd
    runOp(w, 5'd2, 64'h0, 64'h5, PAT_A, 1'b1, 1'b1, 0);
    checkFault("R1", 1);
  endtask

  task automatic t_stall();
    logic [31:0] w;
    int cycA;
    w = mkInstr(9'h1F0, 5'd12, 4'd9);
    stallOn = 1'b1;
    runOp(w, 5'd8, 64'h8000, 64'h0, PAT_A, 1'b1, 1'b0, 0);
    checkStore("R7", w, 5'd8, 64'h8000, PAT_A, 1'b1);
    cycA = lastCycles;
    runOp(w, 5'd8, 64'h8000, 64'h0, PAT_B, 1'b1, 1'b0, 0);
    checkStore("R7", w, 5'd8, 64'h8000, PAT_B, 1'b1);
    chk(lastCycles == cycA, "R9", "data-dependent timing", 64'(lastCycles), 64'(cycA));
    // R10: second start mid-run, with an illegal word
    runOp(w, 5'd8, 64'h8000, 64'h0, PAT_A, 1'b1, 1'b0, 5);
    checkStore("R10", w, 5'd8, 64'h8000, PAT_A, 1'b1);
    chk(!busy && faultCnt == 0, "R10", "extra run started", {busy, 31'(faultCnt)}, 64'd0);
    stallOn = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic();
    t_offsets();
    t_stack();
    t_align();
    t_illegal();
    t_stall();
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog (R8): actual timeout expected completion");
    report();
  end

endmodule